// File: doc/BRIEF.md
# BCH-8 Sector Correction Applier

This block runs after an 8-error-correcting BCH decoder has finished with one 512-byte sector. It takes the decoder's result, which is an error count plus eight 13-bit error locations packed into three 32-bit words and one 8-bit top field. It unpacks the locations and inverts the two low bits of each one to get a data bit index. It then corrects the sector in an external byte-wide RAM by flipping each addressed bit.

Each flip is a read-modify-write. The block reads the byte, XORs it with a one-hot mask and writes it back. Locations are handled one at a time in ascending location order, and only the first *count* locations are used. An index that falls past the data, in the parity area, is passed over and not counted. When the sector is finished, the block raises a one-cycle done pulse. At that point it reports the number of data bits it flipped, or it flags the sector as uncorrectable.

The host drives `start` for one cycle once the decoder reports that its result is ready. The memory read port has one cycle of latency.

Top module: `bch_fix_applier`

## Requirements
- R1: While `rst_n` is low (sampled at the clock edge), `done`, `mem_rd_en` and `mem_wr_en` are held low, and `fix_count` and `uncorrectable` are cleared.
- R2: A `start` pulse is accepted only while `code_ready` is high. Without it, the pulse causes no memory access and no `done`, and the sector is unchanged.
- R3: An `err_count` of 0 finishes the sector with `fix_count` = 0, `uncorrectable` low and no memory write.
- R4: An `err_count` above 8 (9 to 15) finishes the sector with `uncorrectable` high, `fix_count` = 0 and no memory write.
- R5: The 104-bit location vector is `{loc_top, loc_word2, loc_word1, loc_word0}`, and location i occupies bits 13i+12 down to 13i. Location 2 therefore takes its low 6 bits from `loc_word0[31:26]` and its high 7 bits from `loc_word1[6:0]`. Location 7 takes its low 5 bits from `loc_word2[31:27]` and its high 8 bits from `loc_top`.
- R6: Each location is XORed with 3 to form a bit index k. Index k flips bit k&7 of sector byte k>>3.
- R7: An index k at or above 4096 flips nothing and is not counted. The boundary indices 4095 and 4096 fall on either side of this rule.
- R8: `done` is a one-cycle pulse after the last correction. `fix_count` then equals the number of data bits flipped, and it holds until the next accepted start.
- R9: Each flip reads the byte and then, on the next cycle, writes the read value XOR a single-bit mask to the same address. Only locations 0 to count-1 are applied, and they are applied in that order.
- R10: Two equal in-range locations flip the same bit twice, which leaves the byte unchanged. Both flips are still counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin applying the current decoder result |
| code_ready | input | 1 | Decoder result is valid |
| err_count | input | 4 | Number of errors reported by the decoder |
| loc_word0 | input | 32 | Location vector bits 31:0 |
| loc_word1 | input | 32 | Location vector bits 63:32 |
| loc_word2 | input | 32 | Location vector bits 95:64 |
| loc_top | input | 8 | Location vector bits 103:96 |
| mem_addr | output | 9 | Sector RAM byte address |
| mem_rd_en | output | 1 | Sector RAM read strobe (data valid the next cycle) |
| mem_rdata | input | 8 | Sector RAM read data |
| mem_wr_en | output | 1 | Sector RAM write strobe |
| mem_wdata | output | 8 | Sector RAM write data |
| done | output | 1 | One-cycle completion pulse |
| fix_count | output | 4 | Number of data bits flipped |
| uncorrectable | output | 1 | Sector has more errors than can be corrected |

## Verification
The bench targets the packing seams of locations 2 and 7. A design that slices the vector wrongly there flips bytes far from the intended ones. It also exercises the indices 4095 and 4096 around the parity boundary. An off-by-one range check either corrupts nothing visible or wrongly counts a parity hit.

Three further cases cover the control paths. Duplicate locations expose a design that caches the byte instead of re-reading it. A short count with valid locations left beyond it catches a design that walks all eight slots. Counts of 0, 9 and 15, and a start without `code_ready`, show whether the block touches the RAM when it must not.

// File: rtl/bch_fix_pkg.sv
// Shared constants and the state type of the BCH-8 correction applier.
// Assumes a fixed 32-bit word width for the packed location inputs.
package bch_fix_pkg;
    localparam int WORD_W  = 32;
    localparam int CNT_W   = 4;
    localparam int MASK_W  = 8;

    typedef enum logic [1:0] {
        FX_IDLE,
        FX_PICK,
        FX_WRITE,
        FX_FINISH
    } fix_state_e;
endpackage

// File: rtl/bch_loc_unpack.sv
// Splits the packed location vector into NUM_LOC fields of LOC_W bits and
// XORs each field with 3 to get a data bit index. It also flags each index
// that falls inside the data area (below DATA_BITS).
// Assumes NUM_LOC*LOC_W equals three words plus TOP_W top bits.
module bch_loc_unpack
    import bch_fix_pkg::*;
#(
    parameter int NUM_LOC = 8,
    parameter int LOC_W   = 13,
    parameter int IDX_W   = 12,
    parameter int TOP_W   = 8,
    parameter int DATA_BITS = 4096
) (
    input  logic [WORD_W-1:0]                word0,
    input  logic [WORD_W-1:0]                word1,
    input  logic [WORD_W-1:0]                word2,
    input  logic [TOP_W-1:0]                 top,
    output logic [NUM_LOC-1:0][IDX_W-1:0]    bit_idx,
    output logic [NUM_LOC-1:0]               in_data
);
    localparam int PACK_W = NUM_LOC * LOC_W;

    logic [PACK_W-1:0] packed_locs;

    // Concatenate the words with location 0 in the least significant bits.
    assign packed_locs = {top, word2, word1, word0};

    for (genvar gi = 0; gi < NUM_LOC; gi++) begin : g_loc
        logic [LOC_W-1:0] idx_full;

        // Invert the two low bits to form the data bit index.
        assign idx_full = packed_locs[gi*LOC_W +: LOC_W] ^ LOC_W'(3);

        // Keep only the in-sector index bits and flag a parity-area hit.
        assign bit_idx[gi] = idx_full[IDX_W-1:0];
        assign in_data[gi] = ({{(32-LOC_W){1'b0}}, idx_full} < 32'(DATA_BITS));
    end
endmodule

// File: rtl/bch_flip_engine.sv
// Sequencer that applies captured bit indices to the sector RAM, one
// read-modify-write per index, in index-slot order. Counts the flips and
// raises done once the captured count has been walked.
// Assumes the RAM returns read data one cycle after mem_rd_en.
module bch_flip_engine
    import bch_fix_pkg::*;
#(
    parameter int NUM_LOC = 8,
    parameter int IDX_W   = 12,
    parameter int ADDR_W  = 9
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic                           code_ready,
    input  logic [CNT_W-1:0]               err_count,
    input  logic [NUM_LOC-1:0][IDX_W-1:0]  bit_idx,
    input  logic [NUM_LOC-1:0]             in_data,
    output logic [ADDR_W-1:0]              mem_addr,
    output logic                           mem_rd_en,
    input  logic [MASK_W-1:0]              mem_rdata,
    output logic                           mem_wr_en,
    output logic [MASK_W-1:0]              mem_wdata,
    output logic                           done,
    output logic [CNT_W-1:0]               fix_count,
    output logic                           uncorrectable
);
    localparam int SEL_W = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1;
    localparam int BIT_W = IDX_W - ADDR_W;

    fix_state_e                     state;
    logic [CNT_W-1:0]               slot;
    logic [CNT_W-1:0]               slots_total;
    logic [NUM_LOC-1:0][IDX_W-1:0]  idx_q;
    logic [NUM_LOC-1:0]             ok_q;
    logic [SEL_W-1:0]               sel;
    logic [IDX_W-1:0]               cur_idx;
    logic                           slots_left;

    assign sel        = slot[SEL_W-1:0];
    assign cur_idx    = idx_q[sel];
    assign slots_left = (slot != slots_total);

    // Sequence capture, walk and completion; hold the result until the next run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= FX_IDLE;
            slot          <= '0;
            slots_total   <= '0;
            idx_q         <= '0;
            ok_q          <= '0;
            fix_count     <= '0;
            uncorrectable <= 1'b0;
        end else begin
            case (state)
                FX_IDLE: begin
                    if (start && code_ready) begin
                        idx_q     <= bit_idx;
                        ok_q      <= in_data;
                        slot      <= '0;
                        fix_count <= '0;
                        if (err_count > CNT_W'(NUM_LOC)) begin
                            uncorrectable <= 1'b1;
                            slots_total   <= '0;
                            state         <= FX_FINISH;
                        end else begin
                            uncorrectable <= 1'b0;
                            slots_total   <= err_count;
                            state         <= FX_PICK;
                        end
                    end
                end
                FX_PICK: begin
                    if (!slots_left) begin
                        state <= FX_FINISH;
                    end else if (ok_q[sel]) begin
                        state <= FX_WRITE;
                    end else begin
                        slot <= slot + 1'b1;
                    end
                end
                FX_WRITE: begin
                    slot      <= slot + 1'b1;
                    fix_count <= fix_count + 1'b1;
                    state     <= FX_PICK;
                end
                default: begin
                    state <= FX_IDLE;
                end
            endcase
        end
    end

    // Drive the RAM strobes and the flipped byte from the current slot.
    always_comb begin
        mem_addr  = cur_idx[IDX_W-1:BIT_W];
        mem_rd_en = (state == FX_PICK) && slots_left && ok_q[sel];
        mem_wr_en = (state == FX_WRITE);
        mem_wdata = mem_rdata ^ (MASK_W'(1) << cur_idx[BIT_W-1:0]);
        done      = (state == FX_FINISH);
    end
endmodule

// File: rtl/bch_fix_applier.sv
// Top of the BCH-8 correction applier: unpacks the decoder's packed error
// locations and applies them to an external sector RAM bit by bit.
// Assumes the sector RAM is byte wide with one cycle of read latency.
module bch_fix_applier
    import bch_fix_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int NUM_LOC      = 8,
    parameter int LOC_W        = 13
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         code_ready,
    input  logic [3:0]                   err_count,
    input  logic [31:0]                  loc_word0,
    input  logic [31:0]                  loc_word1,
    input  logic [31:0]                  loc_word2,
    input  logic [7:0]                   loc_top,
    output logic [$clog2(SECTOR_BYTES)-1:0] mem_addr,
    output logic                         mem_rd_en,
    input  logic [7:0]                   mem_rdata,
    output logic                         mem_wr_en,
    output logic [7:0]                   mem_wdata,
    output logic                         done,
    output logic [3:0]                   fix_count,
    output logic                         uncorrectable
);
    localparam int ADDR_W    = $clog2(SECTOR_BYTES);
    localparam int DATA_BITS = SECTOR_BYTES * 8;
    localparam int IDX_W     = ADDR_W + 3;
    localparam int TOP_W     = NUM_LOC * LOC_W - 3 * WORD_W;

    logic [NUM_LOC-1:0][IDX_W-1:0] bit_idx;
    logic [NUM_LOC-1:0]            in_data;

    bch_loc_unpack #(
        .NUM_LOC   (NUM_LOC),
        .LOC_W     (LOC_W),
        .IDX_W     (IDX_W),
        .TOP_W     (TOP_W),
        .DATA_BITS (DATA_BITS)
    ) u_unpack (
        .word0   (loc_word0),
        .word1   (loc_word1),
        .word2   (loc_word2),
        .top     (loc_top),
        .bit_idx (bit_idx),
        .in_data (in_data)
    );

    bch_flip_engine #(
        .NUM_LOC (NUM_LOC),
        .IDX_W   (IDX_W),
        .ADDR_W  (ADDR_W)
    ) u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .code_ready    (code_ready),
        .err_count     (err_count),
        .bit_idx       (bit_idx),
        .in_data       (in_data),
        .mem_addr      (mem_addr),
        .mem_rd_en     (mem_rd_en),
        .mem_rdata     (mem_rdata),
        .mem_wr_en     (mem_wr_en),
        .mem_wdata     (mem_wdata),
        .done          (done),
        .fix_count     (fix_count),
        .uncorrectable (uncorrectable)
    );
endmodule

// File: rtl/bch_fix_applier_chk.sv
// Protocol and result checks on the correction applier's ports, bound into
// every instance of the top module.
module bch_fix_applier_chk #(
    parameter int SECTOR_BYTES = 512,
    parameter int NUM_LOC      = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [$clog2(SECTOR_BYTES)-1:0] mem_addr,
    input logic                            mem_rd_en,
    input logic [7:0]                      mem_rdata,
    input logic                            mem_wr_en,
    input logic [7:0]                      mem_wdata,
    input logic                            done,
    input logic [3:0]                      fix_count,
    input logic                            uncorrectable
);
    // R1: a reset cycle leaves the outputs idle and cleared.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!done && !mem_rd_en && !mem_wr_en && fix_count == 4'd0 && !uncorrectable));

    // R8: done never lasts more than one cycle.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the count of flips can never exceed the number of locations.
    a_r8_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fix_count <= 4'(NUM_LOC)));

    // R4: an uncorrectable sector reports no flips.
    a_r4_unc_nofix: assert property (@(posedge clk) disable iff (!rst_n)
        (done && uncorrectable) |-> (fix_count == 4'd0));

    // R9: every write is preceded by a read in the cycle before.
    a_r9_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(mem_rd_en));

    // R9: the write goes back to the address that was read.
    a_r9_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_addr == $past(mem_addr)));

    // R9: the written byte differs from the read byte in exactly one bit.
    a_r9_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($countones(mem_wdata ^ mem_rdata) == 1));

    // R9: read and write strobes are never raised together.
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));
endmodule

bind bch_fix_applier bch_fix_applier_chk #(
    .SECTOR_BYTES (SECTOR_BYTES),
    .NUM_LOC      (NUM_LOC)
) u_chk (.*);

// File: tb/bch_fix_applier_bench.sv
module bch_fix_applier_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int NBYTES     = 512;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        code_ready;
    logic [3:0]  err_count;
    logic [31:0] loc_word0, loc_word1, loc_word2;
    logic [7:0]  loc_top;
    logic [8:0]  mem_addr;
    logic        mem_rd_en;
    logic [7:0]  mem_rdata;
    logic        mem_wr_en;
    logic [7:0]  mem_wdata;
    logic        done;
    logic [3:0]  fix_count;
    logic        uncorrectable;

    logic [7:0]  ram     [NBYTES];
    logic [7:0]  ref_ram [NBYTES];
    logic [12:0] fld     [8];

    int checks    = 0;
    int fails     = 0;
    int wr_seen   = 0;
    int done_seen = 0;
    int cycles    = 0;

    bch_fix_applier u_bch_fix_applier (
        .clk(clk), .rst_n(rst_n), .start(start), .code_ready(code_ready),
        .err_count(err_count), .loc_word0(loc_word0), .loc_word1(loc_word1),
        .loc_word2(loc_word2), .loc_top(loc_top), .mem_addr(mem_addr),
        .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en),
        .mem_wdata(mem_wdata), .done(done), .fix_count(fix_count),
        .uncorrectable(uncorrectable)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Sector RAM model with one cycle of read latency, plus activity counters.
    always @(posedge clk) begin
        cycles++;
        if (mem_wr_en) begin
            ram[mem_addr] <= mem_wdata;
            wr_seen++;
        end
        if (mem_rd_en) mem_rdata <= ram[mem_addr];
        if (done) done_seen++;
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        wait (cycles >= WATCHDOG);
        checks++;
        fails++;
        $display("FAIL R8 watchdog: actual=no completion expected=completion");
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int sector_mismatches();
        int bad = 0;
        for (int i = 0; i < NBYTES; i++)
            if (ram[i] !== ref_ram[i]) bad++;
        return bad;
    endfunction

    function automatic logic [103:0] pack_fields();
        logic [103:0] v;
        for (int i = 0; i < 8; i++) v[i*13 +: 13] = fld[i];
        return v;
    endfunction

    // Apply one decoder result and compare against the bench's own model.
    task automatic run_case(input logic [3:0] cnt, input string req);
        logic [103:0] v;
        int  exp_n = 0;
        bit  exp_u;
        int  k;
        int  wr0;
        int  waited = 0;
        v = pack_fields();
        exp_u = (cnt > 4'd8);
        if (!exp_u) begin
            for (int i = 0; i < int'(cnt); i++) begin
                k = int'(fld[i] ^ 13'd3);
                if (k < 4096) begin
                    ref_ram[k >> 3] = ref_ram[k >> 3] ^ 8'(1 << (k & 7));
                    exp_n++;
                end
            end
        end
        @(negedge clk);
        loc_word0  = v[31:0];
        loc_word1  = v[63:32];
        loc_word2  = v[95:64];
        loc_top    = v[103:96];
        err_count  = cnt;
        code_ready = 1'b1;
        start      = 1'b1;
        wr0        = wr_seen;
        @(negedge clk);
        start     = 1'b0;
        loc_word0 = $urandom();
        loc_word1 = $urandom();
        err_count = 4'($urandom());
        while (!done && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, "R8", "done raised", int'(done), 1);
        check(fix_count == 4'(exp_n), req, "fix_count", int'(fix_count), exp_n);
        check(uncorrectable == exp_u, exp_u ? "R4" : req, "uncorrectable",
              int'(uncorrectable), int'(exp_u));
        check(sector_mismatches() == 0, req, "sector bytes differing", sector_mismatches(), 0);
        if (cnt == 4'd0)
            check(wr_seen == wr0, "R3", "writes on zero count", wr_seen - wr0, 0);
        if (exp_u)
            check(wr_seen == wr0, "R4", "writes when uncorrectable", wr_seen - wr0, 0);
        @(negedge clk);
        check(done == 1'b0, "R8", "done one cycle wide", int'(done), 0);
        check(fix_count == 4'(exp_n), "R8", "fix_count held", int'(fix_count), exp_n);
    endtask

    task automatic random_fields();
        for (int i = 0; i < 8; i++) fld[i] = 13'($urandom_range(0, 4400));
    endtask

    initial begin
        void'($urandom(32'h5EED_0BC8));
        for (int i = 0; i < NBYTES; i++) begin
            ram[i]     = 8'($urandom());
            ref_ram[i] = ram[i];
        end
        rst_n = 1'b0; start = 1'b0; code_ready = 1'b0; err_count = '0;
        loc_word0 = '0; loc_word1 = '0; loc_word2 = '0; loc_top = '0;
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R1", "done in reset", int'(done), 0);
        check(mem_rd_en == 1'b0 && mem_wr_en == 1'b0, "R1", "strobes in reset",
              int'({mem_rd_en, mem_wr_en}), 0);
        check(fix_count == 4'd0, "R1", "fix_count in reset", int'(fix_count), 0);
        check(uncorrectable == 1'b0, "R1", "uncorrectable in reset", int'(uncorrectable), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: start without ready is ignored.
        begin
            logic [103:0] v;
            int d0, w0;
            for (int i = 0; i < 8; i++) fld[i] = 13'(i * 300 + 5);
            v = pack_fields();
            loc_word0 = v[31:0]; loc_word1 = v[63:32]; loc_word2 = v[95:64];
            loc_top = v[103:96]; err_count = 4'd5; code_ready = 1'b0;
            d0 = done_seen; w0 = wr_seen;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (30) @(negedge clk);
            check(done_seen == d0, "R2", "done without ready", done_seen - d0, 0);
            check(wr_seen == w0, "R2", "writes without ready", wr_seen - w0, 0);
            check(sector_mismatches() == 0, "R2", "sector changed", sector_mismatches(), 0);
        end

        random_fields();
        run_case(4'd0, "R3");
        random_fields();
        run_case(4'd9, "R4");
        random_fields();
        run_case(4'd15, "R4");

        // R6: raw 3 -> index 0, raw 0 -> index 3.
        fld[0] = 13'd3;
        run_case(4'd1, "R6");
        fld[0] = 13'd0;
        run_case(4'd1, "R6");

        // R7: indices 4095 and 4092 in range, 4096 and 4099 not.
        fld[0] = 13'd4092; fld[1] = 13'd4099; fld[2] = 13'd4096; fld[3] = 13'd4095;
        run_case(4'd4, "R7");
        for (int i = 0; i < 8; i++) fld[i] = 13'(4100 + i * 500);
        run_case(4'd8, "R7");

        // R5: all eight in range, including the split fields 2 and 7.
        fld[0] = 13'h0011; fld[1] = 13'h0222; fld[2] = 13'h0FC1; fld[3] = 13'h0333;
        fld[4] = 13'h0ABC; fld[5] = 13'h0555; fld[6] = 13'h0E0E; fld[7] = 13'h0A5F;
        run_case(4'd8, "R5");

        // R10: duplicate location cancels but counts twice.
        fld[0] = 13'd100; fld[1] = 13'd100;
        run_case(4'd2, "R10");

        // R9: valid slots beyond the count are not applied.
        for (int i = 0; i < 8; i++) fld[i] = 13'(i * 40 + 9);
        run_case(4'd3, "R9");
        fld[0] = 13'd17; fld[1] = 13'd18; fld[2] = 13'd22;
        run_case(4'd3, "R9");

        for (int n = 0; n < 40; n++) begin
            random_fields();
            run_case(4'($urandom_range(0, 10)), "R8");
        end

        summary();
        $finish;
    end
endmodule